// File: doc/BRIEF.md
# Interrupt Flag Unit with Ring-Neighbour Addressing

This block keeps the eight event flags of one programmable I/O block that runs four instruction sequencers. Each sequencer can issue one flag operation per cycle: set a flag, clear a flag, or set a flag and then hold off until another agent clears it. A five-bit flag index names the flag. The upper two bits of that index choose how the lower three bits are read. They can name a flag of this block directly. They can name one relative to the issuing sequencer's number. They can also name a flag in the next or the previous block of a ring of identical blocks.

Requests that target a neighbour leave on outgoing set/clear buses in the same cycle. The neighbour registers them at the same clock edge as its own requests. A blocking operation aimed at a neighbour therefore watches that neighbour's flag vector, which comes back over the ring. Flags 0..3 drive the processor interrupt logic. The processor clears flags by writing a mask in which each one bit clears a flag.

Top module: `irq_flag_ring`

## Requirements
- R1: After a synchronous active-high reset, all flags are 0, no sequencer is stalled and no neighbour request bus is active.
- R2: Index bits [2:0] give the flag number and bits [4:3] give the mode: 00 is an absolute flag of this block, 10 is relative, 01 is the next block and 11 is the previous block. A local set appears on `flags_o` one cycle after the request.
- R3: In relative mode, sequencer s targets local flag {idx[2], (idx[1:0] + s) mod 4}.
- R4: With `seq_clr` high, the request clears the addressed flag instead of setting it.
- R5: A request in mode 01 or 11 drives exactly one bit of the matching next/previous set or clear bus in the same cycle and leaves the local flags unchanged.
- R6: Set and clear masks arriving from either neighbour update the local flags at the next clock edge.
- R7: When a set and a clear hit the same flag in one cycle, the flag ends up set.
- R8: Each one bit of `host_clr` clears the matching flag at the next edge, unless a set of that flag arrives in the same cycle.
- R9: After a blocking set (wait high, clear low), the sequencer's stall is high from the next cycle for as long as the target flag stays set. Stall drops in the cycle the flag is seen clear. A request without blocking never stalls.
- R10: A blocking set aimed at a neighbour stalls on that neighbour's flag as returned on `nxt_flags_i` / `prv_flags_i`.
- R11: `irq_o` always equals flags 0..3.
- R12: With no set or clear from any source, the flags keep their value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| seq_req | input | 4 | Per-sequencer request strobe |
| seq_clr | input | 4 | Per-sequencer clear option |
| seq_wait | input | 4 | Per-sequencer blocking option |
| seq_idx | input | 20 | Per-sequencer 5-bit index, sequencer s in bits [5s+4:5s] |
| host_clr | input | 8 | Processor write-one-to-clear mask |
| prv_set_i | input | 8 | Sets from the previous block aimed here |
| prv_clr_i | input | 8 | Clears from the previous block aimed here |
| nxt_set_i | input | 8 | Sets from the next block aimed here |
| nxt_clr_i | input | 8 | Clears from the next block aimed here |
| prv_flags_i | input | 8 | Flag vector of the previous block |
| nxt_flags_i | input | 8 | Flag vector of the next block |
| flags_o | output | 8 | Registered flag vector |
| irq_o | output | 4 | Flags 0..3 toward interrupt logic |
| stall_o | output | 4 | Per-sequencer blocking stall |
| nxt_set_o | output | 8 | Sets aimed at the next block |
| nxt_clr_o | output | 8 | Clears aimed at the next block |
| prv_set_o | output | 8 | Sets aimed at the previous block |
| prv_clr_o | output | 8 | Clears aimed at the previous block |

## Verification
A wrong flag register shows on `flags_o` and `irq_o` in the cycle after the faulty update. A bad index decode shows on the neighbour buses in the same cycle, or on `flags_o` one cycle later. A wait tracker that keeps a stale target, or never releases, shows as a `stall_o` that disagrees with the flag it should follow, in the cycle after that flag changes. The bench rebuilds the flag and wait state from the requirements every cycle and compares all outputs in each cycle. Most faults are therefore reported within one or two cycles of the stimulus that exposes them.

// File: rtl/irqx_pkg.sv
package irqx_pkg;
  typedef enum logic [1:0] {
    TGT_LOCAL = 2'd0,
    TGT_NEXT  = 2'd1,
    TGT_PREV  = 2'd2
  } tgt_e;

  // Addressing mode held in the two index bits above the flag number
  localparam logic [1:0] MODE_ABS  = 2'b00;
  localparam logic [1:0] MODE_NEXT = 2'b01;
  localparam logic [1:0] MODE_REL  = 2'b10;
  localparam logic [1:0] MODE_PREV = 2'b11;
endpackage

// File: rtl/irqx_decode.sv
module irqx_decode
  import irqx_pkg::*;
#(
  parameter int NFLAG    = 8,
  parameter int REL_BITS = 2,
  parameter int SEQ_ID   = 0,
  localparam int FW      = $clog2(NFLAG),
  localparam int IDXW    = FW + 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req,
  input  logic             clr,
  input  logic             wait_i,
  input  logic [IDXW-1:0]  idx,
  output logic [NFLAG-1:0] loc_set,
  output logic [NFLAG-1:0] loc_clr,
  output logic [NFLAG-1:0] nxt_set,
  output logic [NFLAG-1:0] nxt_clr,
  output logic [NFLAG-1:0] prv_set,
  output logic [NFLAG-1:0] prv_clr,
  output tgt_e             tgt,
  output logic [FW-1:0]    tgt_idx,
  output logic             blk_set
);
  localparam logic [REL_BITS-1:0] SEQ_OFS = REL_BITS'(SEQ_ID);

  logic [1:0]       mode;
  logic [NFLAG-1:0] onehot;

  always_comb begin
    mode    = idx[FW+1:FW];
    tgt_idx = idx[FW-1:0];
    if (mode == MODE_REL)
      tgt_idx[REL_BITS-1:0] = idx[REL_BITS-1:0] + SEQ_OFS;
    onehot = NFLAG'(1) << tgt_idx;
    case (mode)
      MODE_NEXT: tgt = TGT_NEXT;
      MODE_PREV: tgt = TGT_PREV;
      default:   tgt = TGT_LOCAL;
    endcase
    loc_set = '0; loc_clr = '0;
    nxt_set = '0; nxt_clr = '0;
    prv_set = '0; prv_clr = '0;
    if (req) begin
      case (tgt)
        TGT_NEXT: if (clr) nxt_clr = onehot; else nxt_set = onehot;
        TGT_PREV: if (clr) prv_clr = onehot; else prv_set = onehot;
        default:  if (clr) loc_clr = onehot; else loc_set = onehot;
      endcase
    end
    blk_set = req && wait_i && !clr;
  end

  AST_ONE_TARGET: assert property (@(posedge clk) disable iff (rst)
    $countones({loc_set, loc_clr, nxt_set, nxt_clr, prv_set, prv_clr}) == (req ? 1 : 0)); // R5
endmodule

// File: rtl/irqx_flag_bank.sv
module irqx_flag_bank #(
  parameter int NFLAG = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NFLAG-1:0] set_vec,
  input  logic [NFLAG-1:0] clr_vec,
  input  logic [NFLAG-1:0] host_clr,
  output logic [NFLAG-1:0] flags
);
  always_ff @(posedge clk) begin
    if (rst) flags <= '0;
    else     flags <= (flags & ~clr_vec & ~host_clr) | set_vec;
  end

  AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
    (|set_vec) |=> ((flags & $past(set_vec)) == $past(set_vec))); // R7
  AST_CLR_APPLIES: assert property (@(posedge clk) disable iff (rst)
    (|(clr_vec & ~set_vec)) |=> ((flags & $past(clr_vec & ~set_vec)) == '0)); // R4
  AST_HOST_CLR: assert property (@(posedge clk) disable iff (rst)
    (|(host_clr & ~set_vec)) |=> ((flags & $past(host_clr & ~set_vec)) == '0)); // R8
  AST_HOLD: assert property (@(posedge clk) disable iff (rst)
    (set_vec == '0 && clr_vec == '0 && host_clr == '0) |=> $stable(flags)); // R12
endmodule

// File: rtl/irqx_wait_track.sv
module irqx_wait_track
  import irqx_pkg::*;
#(
  parameter int NFLAG = 8,
  localparam int FW   = $clog2(NFLAG)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req,
  input  logic             blk_set,
  input  tgt_e             tgt,
  input  logic [FW-1:0]    tgt_idx,
  input  logic [NFLAG-1:0] loc_flags,
  input  logic [NFLAG-1:0] nxt_flags,
  input  logic [NFLAG-1:0] prv_flags,
  output logic             stall
);
  logic          waiting;
  tgt_e          tgt_q;
  logic [FW-1:0] idx_q;
  logic [NFLAG-1:0] watched;

  always_comb begin
    case (tgt_q)
      TGT_NEXT: watched = nxt_flags;
      TGT_PREV: watched = prv_flags;
      default:  watched = loc_flags;
    endcase
    stall = waiting && watched[idx_q];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      waiting <= 1'b0;
      tgt_q   <= TGT_LOCAL;
      idx_q   <= '0;
    end else if (req) begin
      waiting <= blk_set;
      tgt_q   <= tgt;
      idx_q   <= tgt_idx;
    end else if (waiting && !watched[idx_q]) begin
      waiting <= 1'b0;
    end
  end

  AST_PLAIN_NO_STALL: assert property (@(posedge clk) disable iff (rst)
    (req && !blk_set) |=> !stall); // R9
  AST_LOCAL_BLOCKS: assert property (@(posedge clk) disable iff (rst)
    (req && blk_set && tgt == TGT_LOCAL) |=> stall); // R9
endmodule

// File: rtl/irq_flag_ring.sv
module irq_flag_ring
  import irqx_pkg::*;
#(
  parameter int NSEQ     = 4,
  parameter int NFLAG    = 8,
  parameter int NIRQ     = 4,
  parameter int REL_BITS = 2,
  localparam int FW      = $clog2(NFLAG),
  localparam int IDXW    = FW + 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NSEQ-1:0]      seq_req,
  input  logic [NSEQ-1:0]      seq_clr,
  input  logic [NSEQ-1:0]      seq_wait,
  input  logic [NSEQ*IDXW-1:0] seq_idx,
  input  logic [NFLAG-1:0]     host_clr,
  input  logic [NFLAG-1:0]     prv_set_i,
  input  logic [NFLAG-1:0]     prv_clr_i,
  input  logic [NFLAG-1:0]     nxt_set_i,
  input  logic [NFLAG-1:0]     nxt_clr_i,
  input  logic [NFLAG-1:0]     prv_flags_i,
  input  logic [NFLAG-1:0]     nxt_flags_i,
  output logic [NFLAG-1:0]     flags_o,
  output logic [NIRQ-1:0]      irq_o,
  output logic [NSEQ-1:0]      stall_o,
  output logic [NFLAG-1:0]     nxt_set_o,
  output logic [NFLAG-1:0]     nxt_clr_o,
  output logic [NFLAG-1:0]     prv_set_o,
  output logic [NFLAG-1:0]     prv_clr_o
);
  logic [NFLAG-1:0] d_ls [NSEQ];
  logic [NFLAG-1:0] d_lc [NSEQ];
  logic [NFLAG-1:0] d_ns [NSEQ];
  logic [NFLAG-1:0] d_nc [NSEQ];
  logic [NFLAG-1:0] d_ps [NSEQ];
  logic [NFLAG-1:0] d_pc [NSEQ];
  tgt_e             d_tgt [NSEQ];
  logic [FW-1:0]    d_idx [NSEQ];
  logic [NSEQ-1:0]  d_blk;

  logic [NFLAG-1:0] loc_set, loc_clr, set_vec, clr_vec;

  genvar s;
  generate
    for (s = 0; s < NSEQ; s++) begin : g_seq
      irqx_decode #(.NFLAG(NFLAG), .REL_BITS(REL_BITS), .SEQ_ID(s)) u_dec (
        .clk(clk), .rst(rst),
        .req(seq_req[s]), .clr(seq_clr[s]), .wait_i(seq_wait[s]),
        .idx(seq_idx[s*IDXW +: IDXW]),
        .loc_set(d_ls[s]), .loc_clr(d_lc[s]),
        .nxt_set(d_ns[s]), .nxt_clr(d_nc[s]),
        .prv_set(d_ps[s]), .prv_clr(d_pc[s]),
        .tgt(d_tgt[s]), .tgt_idx(d_idx[s]), .blk_set(d_blk[s])
      );
      irqx_wait_track #(.NFLAG(NFLAG)) u_wait (
        .clk(clk), .rst(rst),
        .req(seq_req[s]), .blk_set(d_blk[s]),
        .tgt(d_tgt[s]), .tgt_idx(d_idx[s]),
        .loc_flags(flags_o), .nxt_flags(nxt_flags_i), .prv_flags(prv_flags_i),
        .stall(stall_o[s])
      );
    end
  endgenerate

  always_comb begin
    loc_set = '0; loc_clr = '0;
    nxt_set_o = '0; nxt_clr_o = '0;
    prv_set_o = '0; prv_clr_o = '0;
    for (int i = 0; i < NSEQ; i++) begin
      loc_set   |= d_ls[i];
      loc_clr   |= d_lc[i];
      nxt_set_o |= d_ns[i];
      nxt_clr_o |= d_nc[i];
      prv_set_o |= d_ps[i];
      prv_clr_o |= d_pc[i];
    end
    set_vec = loc_set | prv_set_i | nxt_set_i;
    clr_vec = loc_clr | prv_clr_i | nxt_clr_i;
  end

  irqx_flag_bank #(.NFLAG(NFLAG)) u_bank (
    .clk(clk), .rst(rst),
    .set_vec(set_vec), .clr_vec(clr_vec), .host_clr(host_clr),
    .flags(flags_o)
  );

  assign irq_o = flags_o[NIRQ-1:0];

  AST_RING_SET_LANDS: assert property (@(posedge clk) disable iff (rst)
    (|prv_set_i) |=> ((flags_o & $past(prv_set_i)) == $past(prv_set_i))); // R6
endmodule

// File: tb/irq_flag_ring_bench.sv
module irq_flag_ring_bench;
  logic clk = 1'b0;
  logic rst;
  always #10 clk = ~clk;

  logic [3:0]  seq_req, seq_clr, seq_wait;
  logic [19:0] seq_idx;
  logic [7:0]  host_clr, prv_set_i, prv_clr_i, nxt_set_i, nxt_clr_i, prv_flags_i, nxt_flags_i;
  logic [7:0]  flags_o, nxt_set_o, nxt_clr_o, prv_set_o, prv_clr_o;
  logic [3:0]  irq_o, stall_o;

  irq_flag_ring u_irq_flag_ring (
    .clk(clk), .rst(rst), .seq_req(seq_req), .seq_clr(seq_clr), .seq_wait(seq_wait),
    .seq_idx(seq_idx), .host_clr(host_clr), .prv_set_i(prv_set_i), .prv_clr_i(prv_clr_i),
    .nxt_set_i(nxt_set_i), .nxt_clr_i(nxt_clr_i), .prv_flags_i(prv_flags_i),
    .nxt_flags_i(nxt_flags_i), .flags_o(flags_o), .irq_o(irq_o), .stall_o(stall_o),
    .nxt_set_o(nxt_set_o), .nxt_clr_o(nxt_clr_o), .prv_set_o(prv_set_o), .prv_clr_o(prv_clr_o)
  );

  int nchk = 0, nfail = 0;
  bit done = 0;

  // stimulus variables
  logic       rq [4], cl [4], wt [4];
  logic [4:0] ix [4];
  logic [7:0] hc, psi, pci, nsi, nci, rcn, rcp;
  // model state
  logic [7:0] mf, nbn, nbp;
  logic       mw [4];
  logic [1:0] mb [4];
  logic [2:0] mi [4];

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // R2/R3/R5: block 0 local, 1 next, 2 prev
  task automatic dec(input int s, input logic [4:0] x, output logic [1:0] blk, output logic [2:0] n);
    n = x[2:0];
    case (x[4:3])
      2'b01: blk = 2'd1;
      2'b11: blk = 2'd2;
      2'b10: begin blk = 2'd0; n[1:0] = x[1:0] + 2'(s); end
      default: blk = 2'd0;
    endcase
  endtask

  function automatic logic flag_of(logic [1:0] blk, logic [2:0] n);
    return (blk == 2'd1) ? nbn[n] : (blk == 2'd2) ? nbp[n] : mf[n];
  endfunction

  function automatic logic [3:0] exp_stall();
    logic [3:0] r;
    for (int s = 0; s < 4; s++) r[s] = mw[s] && flag_of(mb[s], mi[s]);
    return r;
  endfunction

  task automatic idle();
    for (int s = 0; s < 4; s++) begin rq[s] = 0; cl[s] = 0; wt[s] = 0; ix[s] = '0; end
    hc = 0; psi = 0; pci = 0; nsi = 0; nci = 0; rcn = 0; rcp = 0;
  endtask

  task automatic step(string tag);
    logic [7:0] ls, lc, ens, enc, eps, epc, oh;
    logic [1:0] b; logic [2:0] n;
    for (int s = 0; s < 4; s++) begin
      seq_req[s] = rq[s]; seq_clr[s] = cl[s]; seq_wait[s] = wt[s];
      seq_idx[s*5 +: 5] = ix[s];
    end
    host_clr = hc; prv_set_i = psi; prv_clr_i = pci; nxt_set_i = nsi; nxt_clr_i = nci;
    nxt_flags_i = nbn; prv_flags_i = nbp;
    #2;
    ls = 0; lc = 0; ens = 0; enc = 0; eps = 0; epc = 0;
    for (int s = 0; s < 4; s++) if (rq[s]) begin
      dec(s, ix[s], b, n);
      oh = 8'd1 << n;
      case (b)
        2'd1: if (cl[s]) enc |= oh; else ens |= oh;
        2'd2: if (cl[s]) epc |= oh; else eps |= oh;
        default: if (cl[s]) lc |= oh; else ls |= oh;
      endcase
    end
    chk(tag, {nxt_set_o, nxt_clr_o, prv_set_o, prv_clr_o}, {ens, enc, eps, epc});
    chk(tag, flags_o, mf);
    chk(tag, stall_o, exp_stall());
    chk("R11", irq_o, mf[3:0]);
    @(posedge clk);
    for (int s = 0; s < 4; s++) begin
      if (rq[s]) begin
        dec(s, ix[s], b, n);
        mw[s] = wt[s] && !cl[s]; mb[s] = b; mi[s] = n;
      end else if (mw[s] && !flag_of(mb[s], mi[s])) mw[s] = 0;
    end
    mf  = (mf & ~lc & ~pci & ~nci & ~hc) | ls | psi | nsi;
    nbn = (nbn & ~enc & ~rcn) | ens;
    nbp = (nbp & ~epc & ~rcp) | eps;
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    idle();
    mf = 0; nbn = 0; nbp = 0;
    for (int s = 0; s < 4; s++) begin mw[s] = 0; mb[s] = 0; mi[s] = 0; end
    rst = 1;
    for (int s = 0; s < 4; s++) begin seq_req[s] = 0; seq_clr[s] = 0; seq_wait[s] = 0; end
    seq_idx = 0; host_clr = 0; prv_set_i = 0; prv_clr_i = 0; nxt_set_i = 0; nxt_clr_i = 0;
    prv_flags_i = 0; nxt_flags_i = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    step("R1");
    // R2 absolute local set of flag 5
    rq[0] = 1; ix[0] = 5'h05; step("R2"); idle(); step("R2");
    // R3 relative: seq3 idx low 1 -> flag 0; seq2 idx 7 -> flag 5
    rq[3] = 1; ix[3] = 5'h11; step("R3"); idle(); step("R3");
    chk("R3", flags_o[0], 1'b1);
    rq[2] = 1; ix[2] = 5'h17; rq[1] = 1; cl[1] = 1; ix[1] = 5'h05; step("R3"); idle(); step("R3");
    // R4 clear flag 0
    rq[1] = 1; cl[1] = 1; ix[1] = 5'h00; step("R4"); idle(); step("R4");
    chk("R4", flags_o[0], 1'b0);
    // R5 next and previous targets
    rq[0] = 1; ix[0] = 5'h0A; rq[1] = 1; ix[1] = 5'h1C; step("R5"); idle(); step("R5");
    // R6 incoming ring sets and clears
    psi = 8'h80; nsi = 8'h02; step("R6"); idle();
    nci = 8'h80; step("R6"); idle(); step("R6");
    // R7 set and clear of flag 6 in one cycle
    rq[0] = 1; ix[0] = 5'h06; rq[1] = 1; cl[1] = 1; ix[1] = 5'h06; step("R7"); idle(); step("R7");
    chk("R7", flags_o[6], 1'b1);
    // R8 host clear loses to a set, then wins alone
    hc = 8'h40; rq[2] = 1; ix[2] = 5'h06; step("R8"); idle(); step("R8");
    hc = 8'h40; step("R8"); idle(); step("R8");
    chk("R8", flags_o[6], 1'b0);
    // R9 blocking local set of flag 7, released by host
    rq[2] = 1; wt[2] = 1; ix[2] = 5'h07; step("R9"); idle();
    repeat (3) step("R9");
    chk("R9", stall_o[2], 1'b1);
    hc = 8'h80; step("R9"); idle(); step("R9");
    chk("R9", stall_o[2], 1'b0);
    // R9 clear with wait does not block
    rq[3] = 1; wt[3] = 1; cl[3] = 1; ix[3] = 5'h03; step("R9"); idle(); step("R9");
    // R10 blocking set on next block flag 3, released by neighbour
    rq[1] = 1; wt[1] = 1; ix[1] = 5'h0B; step("R10"); idle();
    repeat (2) step("R10");
    chk("R10", stall_o[1], 1'b1);
    rcn = 8'h08; step("R10"); idle(); step("R10");
    chk("R10", stall_o[1], 1'b0);
    // R10 previous block
    rq[0] = 1; wt[0] = 1; ix[0] = 5'h19; step("R10"); idle(); step("R10");
    rcp = 8'h02; step("R10"); idle(); step("R10");
    // R12 random mix
    for (int k = 0; k < 4000; k++) begin
      logic [3:0] st;
      st = exp_stall();
      for (int s = 0; s < 4; s++) begin
        rq[s] = ($urandom % 4 == 0) && !st[s];
        cl[s] = ($urandom % 3 == 0);
        wt[s] = ($urandom % 3 == 0);
        ix[s] = 5'($urandom);
      end
      hc  = ($urandom % 6 == 0) ? 8'($urandom) : 8'h0;
      psi = ($urandom % 8 == 0) ? 8'($urandom) : 8'h0;
      pci = ($urandom % 8 == 0) ? 8'($urandom) : 8'h0;
      nsi = ($urandom % 8 == 0) ? 8'($urandom) : 8'h0;
      nci = ($urandom % 8 == 0) ? 8'($urandom) : 8'h0;
      rcn = ($urandom % 4 == 0) ? 8'($urandom) : 8'h0;
      rcp = ($urandom % 4 == 0) ? 8'($urandom) : 8'h0;
      step("R12");
    end
    idle(); step("R12");
    done = 1;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule